// File: doc/BRIEF.md
# Spindle Motor State Tracker

This block follows the spindle motor of each of four floppy drives through a four-state cycle: stopped, spinning up, ready and spinning down. Software controls the motors through a single drive-control byte. Each write names one drive and either asks for its motor to run or asks for it to stop. Stopping is not instantaneous. A drive that is told to stop spins down for a timed interval. If it is told to run again during that interval, it goes straight back to ready with no new spin-up delay.

A free-running cycle counter provides timing. Every drive captures a timestamp when it starts a timed phase. It leaves that phase once the wrap-safe difference between the counter and the timestamp reaches the settle duration. The settle duration is an input, normally set to one second's worth of system clock cycles.

For each drive the block outputs:
- its state;
- a ready flag;
- the number of spin-up cycles still to go, which a downstream timing unit can add to its own delays.

All pins are plain control and status; there is no streaming interface, so there is no back-pressure.

Top module: `spindle_tracker`

## Requirements
- R1: A command is taken only in a cycle where `ctl_wr` is high. `ctl_data[1:0]` selects the drive and `ctl_data[7]` gives the request: 1 means motor on, 0 means motor off. Bits 6..2 have no effect.
- R2: Each drive keeps its own state and its own timestamp. A command changes only the selected drive.
- R3: Motor-on to a stopped drive moves it to spinning-up on the next edge and records the current counter value.
- R4: Motor-on to a spinning-down drive moves it to ready on the next edge and records no new timestamp.
- R5: Motor-off to a drive that is spinning up or ready moves it to spinning-down and records the current counter value.
- R6: A spinning-up drive becomes ready on the first edge at which (counter − timestamp) mod 2^CNT_W is at least `settle_cycles`.
- R7: A spinning-down drive becomes stopped under the same elapsed-time condition as R6.
- R8: These commands leave the drive's state unchanged:
  - motor-on to a ready or spinning-up drive;
  - motor-off to a stopped or spinning-down drive.
- R9: While `rst_n` is low, every drive is stopped, every ready flag is 0, every remaining count is 0, and the counter restarts from 0.
- R10: Elapsed time uses an unsigned modulo-2^CNT_W difference, so timing stays correct across counter wrap.
- R11: The state encoding is stopped=0, spinning-up=1, ready=2, spinning-down=3, and drive d sits at `drv_state[2d+1:2d]`. `drv_ready[d]` is 1 exactly in ready. `spinup_left[CNT_W*d +: CNT_W]` is `settle_cycles − elapsed` while spinning up and not yet settled, and 0 otherwise.
- R12: When a command that changes state (R4, R5) arrives on the same edge as a timer expiry (R6, R7), the command wins. A no-change command (R8) does not block the timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_wr | input | 1 | Drive-control write strobe |
| ctl_data | input | 8 | Drive-control byte: drive select in [1:0], motor request in [7] |
| settle_cycles | input | CNT_W | Spin-up and spin-down duration in cycles |
| drv_state | output | 2*NUM_DRIVES | Per-drive motor state |
| drv_ready | output | NUM_DRIVES | Per-drive ready flag |
| spinup_left | output | CNT_W*NUM_DRIVES | Per-drive remaining spin-up cycles |

## Verification
The bench builds the block with four drives and an 8-bit cycle counter. With that counter width, the counter wraps several times during the run, so the wrap-safe difference of R10 is exercised rather than assumed.

Settle durations of 0, 1, 2, 3 and 6 cycles keep each timed phase short. This makes it possible to sweep motor-off over every offset inside spin-up, including the exact expiry edge covered by R12. The sweep repeats on every drive, with writes to the other drives interleaved.

// File: rtl/spindle_pkg.sv
package spindle_pkg;
  typedef enum logic [1:0] {
    MS_STOPPED = 2'd0,
    MS_SPINUP  = 2'd1,
    MS_READY   = 2'd2,
    MS_SPINDN  = 2'd3
  } motor_state_t;
endpackage

// File: rtl/spindle_cycle_counter.sv
module spindle_cycle_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [CNT_W-1:0] now
);
  always_ff @(posedge clk) begin
    if (!rst_n) now <= '0;
    else        now <= now + 1'b1;
  end

  // R10: counter advances by one every cycle, wrapping modulo 2^CNT_W
  assert_counter_steps_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> now == CNT_W'($past(now) + 1'b1));
endmodule

// File: rtl/spindle_cmd_decode.sv
module spindle_cmd_decode #(
  parameter int NUM_DRIVES = 4,
  localparam int SEL_W = (NUM_DRIVES > 1) ? $clog2(NUM_DRIVES) : 1
) (
  input  logic                  wr,
  input  logic [7:0]            data,
  output logic [NUM_DRIVES-1:0] hit,
  output logic                  motor_on
);
  logic [SEL_W-1:0] sel;
  assign sel      = data[SEL_W-1:0];
  assign motor_on = data[7];

  for (genvar d = 0; d < NUM_DRIVES; d++) begin : g_hit
    assign hit[d] = wr && (sel == SEL_W'(d));
  end

  // R1/R2: at most one drive addressed per write
  always_comb assert_one_drive_R2: assert ($onehot0(hit));
endmodule

// File: rtl/spindle_drive_fsm.sv
module spindle_drive_fsm
  import spindle_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] now,
  input  logic [CNT_W-1:0] settle,
  input  logic             cmd_hit,
  input  logic             cmd_on,
  output motor_state_t     state,
  output logic             ready,
  output logic [CNT_W-1:0] left
);
  motor_state_t     st_q, st_d;
  logic [CNT_W-1:0] stamp_q, stamp_d;
  logic [CNT_W-1:0] elapsed;
  logic             settled;

  assign elapsed = now - stamp_q;   // modulo 2^CNT_W
  assign settled = elapsed >= settle;

  always_comb begin
    st_d    = st_q;
    stamp_d = stamp_q;
    unique case (st_q)
      MS_STOPPED: if (cmd_hit && cmd_on) begin
        st_d    = MS_SPINUP;
        stamp_d = now;
      end
      MS_SPINUP: begin
        if (cmd_hit && !cmd_on) begin
          st_d    = MS_SPINDN;
          stamp_d = now;
        end else if (settled) begin
          st_d = MS_READY;
        end
      end
      MS_READY: if (cmd_hit && !cmd_on) begin
        st_d    = MS_SPINDN;
        stamp_d = now;
      end
      MS_SPINDN: begin
        if (cmd_hit && cmd_on)  st_d = MS_READY;
        else if (settled)       st_d = MS_STOPPED;
      end
      default: st_d = MS_STOPPED;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= MS_STOPPED;
      stamp_q <= '0;
    end else begin
      st_q    <= st_d;
      stamp_q <= stamp_d;
    end
  end

  assign state = st_q;
  assign ready = (st_q == MS_READY);
  assign left  = (st_q == MS_SPINUP && !settled) ? (settle - elapsed) : '0;

  assert_stop_never_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == MS_STOPPED) |=> (st_q != MS_READY));
  assert_spinup_needs_cmd_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == MS_SPINUP && $past(st_q) == MS_STOPPED) |-> $past(cmd_hit && cmd_on));
  assert_ready_not_respun_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == MS_READY) |=> (st_q != MS_SPINUP && st_q != MS_STOPPED));
  assert_stop_from_spindn_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_q == MS_STOPPED) |-> ($past(st_q) == MS_SPINDN));
  assert_ready_flag_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (left != '0) |-> (!ready && st_q == MS_SPINUP));
endmodule

// File: rtl/spindle_tracker.sv
module spindle_tracker
  import spindle_pkg::*;
#(
  parameter int NUM_DRIVES = 4,
  parameter int CNT_W      = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        ctl_wr,
  input  logic [7:0]                  ctl_data,
  input  logic [CNT_W-1:0]            settle_cycles,
  output logic [2*NUM_DRIVES-1:0]     drv_state,
  output logic [NUM_DRIVES-1:0]       drv_ready,
  output logic [CNT_W*NUM_DRIVES-1:0] spinup_left
);
  logic [CNT_W-1:0]      now;
  logic [NUM_DRIVES-1:0] hit;
  logic                  motor_on;

  spindle_cycle_counter #(.CNT_W(CNT_W)) i_counter (
    .clk(clk), .rst_n(rst_n), .now(now)
  );

  spindle_cmd_decode #(.NUM_DRIVES(NUM_DRIVES)) i_decode (
    .wr(ctl_wr), .data(ctl_data), .hit(hit), .motor_on(motor_on)
  );

  for (genvar d = 0; d < NUM_DRIVES; d++) begin : g_drive
    motor_state_t st;
    spindle_drive_fsm #(.CNT_W(CNT_W)) i_fsm (
      .clk(clk), .rst_n(rst_n), .now(now), .settle(settle_cycles),
      .cmd_hit(hit[d]), .cmd_on(motor_on),
      .state(st), .ready(drv_ready[d]),
      .left(spinup_left[CNT_W*d +: CNT_W])
    );
    assign drv_state[2*d +: 2] = st;

    // R2: an idle drive is only moved by its own timer or its own command
    assert_idle_untouched_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (st == MS_READY && !hit[d]) |=> (st == MS_READY));
  end
endmodule

// File: tb/test_spindle_tracker.sv
module test_spindle_tracker;
  localparam int ND = 4;
  localparam int CW = 8;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              ctl_wr = 1'b0;
  logic [7:0]        ctl_data = '0;
  logic [CW-1:0]     settle_cycles = '0;
  logic [2*ND-1:0]   drv_state;
  logic [ND-1:0]     drv_ready;
  logic [CW*ND-1:0]  spinup_left;

  always #10 clk = ~clk;   // 50 MHz

  spindle_tracker #(.NUM_DRIVES(ND), .CNT_W(CW)) i_spindle_tracker (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_data(ctl_data),
    .settle_cycles(settle_cycles), .drv_state(drv_state),
    .drv_ready(drv_ready), .spinup_left(spinup_left)
  );

  int    n_checks = 0;
  int    n_fail = 0;
  int    cyc = 0;            // counter value before the next edge
  int    S = 0;
  int    st_m [ND];
  int    el_m [ND];
  string tg [ND];
  bit    ended = 1'b0;

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic finish_up();
    if (!ended) begin
      ended = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  task automatic compare_all();
    for (int d = 0; d < ND; d++) begin
      int exp_left;
      exp_left = (st_m[d] == 1 && el_m[d] < S) ? (S - el_m[d]) : 0;
      chk(tg[d], int'(drv_state[2*d +: 2]), st_m[d]);
      chk("R11 ready", int'(drv_ready[d]), (st_m[d] == 2) ? 1 : 0);
      chk("R11 left", int'(spinup_left[CW*d +: CW]), exp_left);
    end
  endtask

  task automatic model_edge(input bit w, input logic [7:0] dat);
    for (int d = 0; d < ND; d++) begin
      bit hit, on, done, stamp;
      int ns;
      string t;
      hit = w && (int'(dat[1:0]) == d);
      on = dat[7];
      done = (el_m[d] >= S);
      stamp = 1'b0;
      ns = st_m[d];
      t = (w && !hit) ? "R2" : tg[d];
      case (st_m[d])
        0: if (hit && on) begin ns = 1; stamp = 1; t = (dat[6:2] != 0) ? "R1" : "R3"; end
           else if (hit) t = "R8";
        1: if (hit && !on) begin ns = 3; stamp = 1; t = done ? "R12" : "R5"; end
           else if (done) begin ns = 2; t = (cyc >= 256) ? "R10" : "R6"; end
           else if (hit) t = "R8";
        2: if (hit && !on) begin ns = 3; stamp = 1; t = "R5"; end
           else if (hit) t = "R8";
        default: if (hit && on) begin ns = 2; t = done ? "R12" : "R4"; end
           else if (done) begin ns = 0; t = (cyc >= 256) ? "R10" : "R7"; end
           else if (hit) t = "R8";
      endcase
      st_m[d] = ns;
      el_m[d] = stamp ? 1 : ((el_m[d] < 100000) ? el_m[d] + 1 : el_m[d]);
      tg[d] = t;
    end
    cyc++;
  endtask

  // starts and ends at a falling edge
  task automatic tick(input bit w, input logic [7:0] dat);
    ctl_wr = w;
    ctl_data = dat;
    @(posedge clk);
    model_edge(w, dat);
    @(negedge clk);
    ctl_wr = 1'b0;
    ctl_data = '0;
    compare_all();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick(1'b0, 8'h00);
  endtask

  task automatic motor(input int d, input bit on);
    tick(1'b1, {on, 5'b0, 2'(d)});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    finish_up();
  end

  initial begin
    int settles [5] = '{0, 1, 2, 3, 6};
    for (int d = 0; d < ND; d++) begin st_m[d] = 0; el_m[d] = 0; tg[d] = "R9"; end
    repeat (3) @(negedge clk);
    compare_all();           // R9 reset state
    rst_n = 1'b1;
    foreach (settles[k]) begin
      S = settles[k];
      settle_cycles = CW'(S);
      for (int d = 0; d < ND; d++) begin
        motor(d, 1'b1); idle(S + 2);          // R3, R6
        motor(d, 1'b1);                        // R8 on to ready
        motor(d, 1'b0); idle(1);               // R5
        motor(d, 1'b1);                        // R4
        motor(d, 1'b0); idle(S + 2);           // R7
        motor(d, 1'b0);                        // R8 off to stopped
        tick(1'b1, 8'hFC | 8'(d)); idle(1);    // R1 junk bits
        motor(d, 1'b1);                        // R8 on to spin-up
        motor(d, 1'b0); idle(S + 2);
        for (int j = 0; j <= S + 1; j++) begin // R12 sweep
          motor(d, 1'b1); idle(j);
          motor(d, 1'b0);
          motor((d + 1) % ND, 1'b1);           // R2 neighbour write
          idle(S + 1);
          motor((d + 1) % ND, 1'b0); idle(S + 2);
        end
      end
      for (int d = 0; d < ND; d++) motor(d, 1'b1);
      idle(S + 2);
      for (int d = 0; d < ND; d++) motor(d, 1'b0);
      idle(S + 2);
    end
    tick(1'b1, 8'h81);
    rst_n = 1'b0;
    @(posedge clk);
    for (int d = 0; d < ND; d++) begin st_m[d] = 0; tg[d] = "R9"; end
    @(negedge clk);
    compare_all();
    finish_up();
  end
endmodule